// File: doc/BRIEF.md
# Recirculating Serial Output Shifter

This block is the parallel-to-serial output stage that follows a speech codec core. Each time the frame strobe falls, it captures one result word: an 8-bit PCM sample or an ADPCM code word. It also captures which kind of word it is and, for ADPCM, the rate mode, which sets whether the code is five or four bits long. When the strobe goes high again, the output window opens. The most significant bit appears at once. Each rising edge of the bit clock that belongs to the captured word type moves the output to the next lower bit.

If the bit clock supplies more edges than the word has bits, the shifter does not emit fill bits. It wraps back to the most significant bit and sends the word again. The wrap length is 8 for PCM, 5 for the full-rate ADPCM mode and 4 for the reduced-rate ADPCM modes. The output-enable pin follows the frame strobe, so the pad driver sits outside this block.

The strobe and both bit clocks are slow external signals. They pass through `SYNC_STG` synchroniser flops on the system clock, and their edges are detected after that. Every response therefore follows its cause by a few system-clock cycles. The data inputs are sampled in the cycle in which the falling strobe edge is detected.

Top module: `recirc_ser_out`

## Requirements
- R1: While reset is asserted and after reset is released, `oe_o` is 0 and `ser_o` is the idle level (0 by default).
- R2: While `frame_i` is low, `oe_o` is 0 and `ser_o` stays at the idle level, whatever either bit clock does.
- R3: A falling edge of `frame_i` captures `src_sel_i` (0 = PCM, 1 = ADPCM), `rate_i`, `pcm_word_i` and `adp_word_i`. Changes to these inputs after the capture have no effect on the output until the next falling edge.
- R4: After a rising edge of `frame_i`, `oe_o` is 1 and `ser_o` carries the most significant bit of the captured word before any bit-clock edge.
- R5: While the window is open, each rising edge of the selected bit clock moves `ser_o` to the next lower bit. The selected clock is `pcm_bclk_i` for PCM and `adp_bclk_i` for ADPCM.
- R6: A PCM word is sent as bits 7 down to 0. The 8th rising edge returns the output to bit 7.
- R7: With `rate_i` = 2'b00 (full rate), an ADPCM word is sent as `adp_word_i` bits 4 down to 0. The 5th rising edge returns the output to bit 4.
- R8: With any other `rate_i` value, an ADPCM word is sent as `adp_word_i` bits 3 down to 0, and bit 4 never appears. The 4th rising edge returns the output to bit 3.
- R9: Rising edges of the bit clock that is not selected do not move the output.
- R10: Falling edges of the selected bit clock do not move the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | Frame strobe. The falling edge loads a word; the high level opens the output window |
| src_sel_i | input | 1 | Word type captured at load: 0 = PCM, 1 = ADPCM |
| rate_i | input | 2 | ADPCM rate mode: 2'b00 = 5-bit word, any other value = 4-bit word |
| pcm_word_i | input | PCM_W | Parallel PCM result |
| adp_word_i | input | ADP_W | Parallel ADPCM result; the 4-bit codes use the low bits |
| pcm_bclk_i | input | 1 | PCM bit clock; idles high |
| adp_bclk_i | input | 1 | ADPCM bit clock; idles high |
| ser_o | output | 1 | Serial data out, MSB first |
| oe_o | output | 1 | Output enable for the external pad driver |

## Verification
The bench builds the block with its defaults: PCM_W = 8, ADP_W = 5, ADP_SHORT_W = 4 and SYNC_STG = 2. These values bring all three wrap lengths (8, 5 and 4) within reach, along with the synchroniser variant of the edge detector. Each bit clock is pulsed up to 17 times per window, so every wrap is crossed at least twice. The bench also toggles the unselected clock, changes the inputs after capture, and fills bit 4 with a value in the 4-bit modes, which shows whether that bit leaks into the output.

// File: rtl/recirc_ser_pkg.sv
package recirc_ser_pkg;

   typedef enum logic {
      SRC_PCM = 1'b0,
      SRC_ADP = 1'b1
   } src_e;

   localparam logic [1:0] RATE_FULL = 2'b00;

   function automatic int unsigned word_len(input src_e s, input logic full,
                                            input int unsigned pw,
                                            input int unsigned aw,
                                            input int unsigned sw);
      if (s == SRC_PCM) return pw;
      else if (full)    return aw;
      else              return sw;
   endfunction

endpackage

// File: rtl/rso_edge_det.sv
module rso_edge_det #(
   parameter int unsigned SYNC_STG = 2,
   parameter logic        RST_LVL  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic lvl_o,
   output logic prev_o
);

   generate
      if (SYNC_STG == 0) begin : g_direct
         assign lvl_o = lvl_i;
      end else begin : g_sync
         logic [SYNC_STG-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= {SYNC_STG{RST_LVL}};
            end else begin
               sh_q[0] <= lvl_i;
               for (int i = 1; i < SYNC_STG; i++) sh_q[i] <= sh_q[i-1];
            end
         end
         assign lvl_o = sh_q[SYNC_STG-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_o <= RST_LVL;
      else        prev_o <= lvl_o;
   end

endmodule

// File: rtl/rso_word_load.sv
module rso_word_load
   import recirc_ser_pkg::*;
#(
   parameter int unsigned PCM_W       = 8,
   parameter int unsigned ADP_W       = 5,
   parameter int unsigned ADP_SHORT_W = 4,
   parameter int unsigned BUF_W       = 8,
   parameter int unsigned CNT_W       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             sel_i,
   input  logic [1:0]       rate_i,
   input  logic [PCM_W-1:0] pcm_i,
   input  logic [ADP_W-1:0] adp_i,
   output logic [BUF_W-1:0] buf_o,
   output logic [CNT_W-1:0] last_o,
   output src_e             src_o
);

   src_e             nxt_src;
   logic             nxt_full;
   logic [BUF_W-1:0] nxt_buf;
   logic [CNT_W-1:0] nxt_last;

   always_comb begin
      nxt_src  = src_e'(sel_i);
      nxt_full = (rate_i == RATE_FULL);
      nxt_last = CNT_W'(word_len(nxt_src, nxt_full, PCM_W, ADP_W, ADP_SHORT_W) - 1);
      if (nxt_src == SRC_PCM)  nxt_buf = BUF_W'(pcm_i);
      else if (nxt_full)       nxt_buf = BUF_W'(adp_i);
      else                     nxt_buf = BUF_W'(adp_i[ADP_SHORT_W-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_o  <= '0;
         last_o <= CNT_W'(PCM_W - 1);
         src_o  <= SRC_PCM;
      end else if (load_i) begin
         buf_o  <= nxt_buf;
         last_o <= nxt_last;
         src_o  <= nxt_src;
      end
   end

endmodule

// File: rtl/rso_bit_ptr.sv
module rso_bit_ptr #(
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             step_i,
   input  logic [CNT_W-1:0] last_i,
   output logic [CNT_W-1:0] idx_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            idx_o <= '0;
      else if (restart_i)    idx_o <= '0;
      else if (step_i) begin
         if (idx_o == last_i) idx_o <= '0;
         else                 idx_o <= idx_o + 1'b1;
      end
   end

endmodule

// File: rtl/recirc_ser_out.sv
module recirc_ser_out
   import recirc_ser_pkg::*;
#(
   parameter int unsigned PCM_W       = 8,
   parameter int unsigned ADP_W       = 5,
   parameter int unsigned ADP_SHORT_W = 4,
   parameter int unsigned SYNC_STG    = 2,
   parameter logic        IDLE_LVL    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_i,
   input  logic             src_sel_i,
   input  logic [1:0]       rate_i,
   input  logic [PCM_W-1:0] pcm_word_i,
   input  logic [ADP_W-1:0] adp_word_i,
   input  logic             pcm_bclk_i,
   input  logic             adp_bclk_i,
   output logic             ser_o,
   output logic             oe_o
);

   localparam int unsigned BUF_W = (PCM_W > ADP_W) ? PCM_W : ADP_W;
   localparam int unsigned CNT_W = (BUF_W > 2) ? $clog2(BUF_W) : 1;

   generate
      if (PCM_W < 2) begin : g_bad_pcm
         $error("PCM_W must be at least 2");
      end
      if (ADP_SHORT_W < 2 || ADP_SHORT_W >= ADP_W) begin : g_bad_adp
         $error("ADP_SHORT_W must be at least 2 and below ADP_W");
      end
      if (SYNC_STG > 4) begin : g_bad_sync
         $error("SYNC_STG must not exceed 4");
      end
   endgenerate

   logic fr_lvl, fr_prev, pck_lvl, pck_prev, ack_lvl, ack_prev;

   rso_edge_det #(.SYNC_STG(SYNC_STG), .RST_LVL(1'b0)) u_fr (
      .clk(clk), .rst_n(rst_n), .lvl_i(frame_i), .lvl_o(fr_lvl), .prev_o(fr_prev));
   rso_edge_det #(.SYNC_STG(SYNC_STG), .RST_LVL(1'b1)) u_pck (
      .clk(clk), .rst_n(rst_n), .lvl_i(pcm_bclk_i), .lvl_o(pck_lvl), .prev_o(pck_prev));
   rso_edge_det #(.SYNC_STG(SYNC_STG), .RST_LVL(1'b1)) u_ack (
      .clk(clk), .rst_n(rst_n), .lvl_i(adp_bclk_i), .lvl_o(ack_lvl), .prev_o(ack_prev));

   logic fr_rise, fr_fall, pck_rise, ack_rise, win_q, step;
   assign fr_rise  = fr_lvl & ~fr_prev;
   assign fr_fall  = ~fr_lvl & fr_prev;
   assign pck_rise = pck_lvl & ~pck_prev;
   assign ack_rise = ack_lvl & ~ack_prev;
   assign win_q    = fr_prev;

   logic [BUF_W-1:0] buf_q;
   logic [CNT_W-1:0] last_q, idx_q, pos;
   src_e             src_q;

   rso_word_load #(
      .PCM_W(PCM_W), .ADP_W(ADP_W), .ADP_SHORT_W(ADP_SHORT_W),
      .BUF_W(BUF_W), .CNT_W(CNT_W)
   ) u_load (
      .clk(clk), .rst_n(rst_n), .load_i(fr_fall), .sel_i(src_sel_i),
      .rate_i(rate_i), .pcm_i(pcm_word_i), .adp_i(adp_word_i),
      .buf_o(buf_q), .last_o(last_q), .src_o(src_q));

   assign step = win_q & fr_lvl & ((src_q == SRC_PCM) ? pck_rise : ack_rise);

   rso_bit_ptr #(.CNT_W(CNT_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .restart_i(fr_rise), .step_i(step),
      .last_i(last_q), .idx_o(idx_q));

   assign pos   = last_q - idx_q;
   assign ser_o = win_q ? buf_q[pos] : IDLE_LVL;
   assign oe_o  = win_q;

   // R2: a closed window shows the idle level on the next cycle
   a_r2_idle_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
      !fr_lvl |=> (ser_o == IDLE_LVL));
   // R3: the captured type follows the select input at the load edge
   a_r3_capture_type: assert property (@(posedge clk) disable iff (!rst_n)
      fr_fall |=> (src_q == src_e'($past(src_sel_i))));
   // R4: opening the window points at the MSB
   a_r4_msb_on_open: assert property (@(posedge clk) disable iff (!rst_n)
      fr_rise |=> (idx_q == '0));
   // R5: pointer never passes the word length while the window is open
   a_r5_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      win_q |-> (idx_q <= last_q));
   // R5: a step below the last bit advances by one
   a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (step && idx_q != last_q) |=> (idx_q == CNT_W'($past(idx_q) + 1'b1)));
   // R6: a step at the last bit wraps back to the MSB
   a_r6_wrap_to_msb: assert property (@(posedge clk) disable iff (!rst_n)
      (step && idx_q == last_q) |=> (idx_q == '0));
   // R9: without a selected rising edge the pointer holds
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (win_q && !step) |=> $stable(idx_q));

endmodule

// File: tb/sim_recirc_ser_out.sv
module sim_recirc_ser_out;

   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_i = 1'b0;
   logic       src_sel_i = 1'b0;
   logic [1:0] rate_i = 2'b00;
   logic [7:0] pcm_word_i = '0;
   logic [4:0] adp_word_i = '0;
   logic       pcm_bclk_i = 1'b1;
   logic       adp_bclk_i = 1'b1;
   logic       ser_o, oe_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   recirc_ser_out u0 (
      .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .src_sel_i(src_sel_i),
      .rate_i(rate_i), .pcm_word_i(pcm_word_i), .adp_word_i(adp_word_i),
      .pcm_bclk_i(pcm_bclk_i), .adp_bclk_i(adp_bclk_i), .ser_o(ser_o), .oe_o(oe_o));

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   function automatic logic exp_bit(input bit adp, input logic [1:0] rate,
                                    input logic [7:0] pw, input logic [4:0] aw,
                                    input int k);
      int len;
      logic [7:0] w;
      if (!adp)              begin len = 8; w = pw; end
      else if (rate == 2'b00) begin len = 5; w = {3'b0, aw}; end
      else                   begin len = 4; w = {4'b0, aw[3:0]}; end
      return w[len - 1 - (k % len)];
   endfunction

   function automatic int wrap_len(input bit adp, input logic [1:0] rate);
      if (!adp) return 8;
      return (rate == 2'b00) ? 5 : 4;
   endfunction

   task automatic run_frame(input bit adp, input logic [1:0] rate,
                            input logic [7:0] pw, input logic [4:0] aw,
                            input int edges, input bit noise);
      string wreq;
      wreq = !adp ? "R6" : (rate == 2'b00 ? "R7" : "R8");
      src_sel_i = adp; rate_i = rate; pcm_word_i = pw; adp_word_i = aw;
      frame_i = 1'b0;
      step(SETTLE);
      check("R2 oe closed", oe_o, 1'b0);
      check("R2 idle", ser_o, 1'b0);
      pcm_bclk_i = 1'b0; adp_bclk_i = 1'b0; step(SETTLE);
      pcm_bclk_i = 1'b1; adp_bclk_i = 1'b1; step(SETTLE);
      check("R2 idle after clocks", ser_o, 1'b0);
      // R3: scramble inputs after capture
      src_sel_i = ~adp; rate_i = ~rate; pcm_word_i = ~pw; adp_word_i = ~aw;
      frame_i = 1'b1;
      step(SETTLE);
      check("R4 oe open", oe_o, 1'b1);
      check("R4 msb first / R3 captured", ser_o, exp_bit(adp, rate, pw, aw, 0));
      for (int k = 1; k <= edges; k++) begin
         if (noise) begin
            if (adp) pcm_bclk_i = 1'b0; else adp_bclk_i = 1'b0;
            step(SETTLE);
            pcm_bclk_i = 1'b1; adp_bclk_i = 1'b1;
            step(SETTLE);
            check("R9 other clock ignored", ser_o, exp_bit(adp, rate, pw, aw, k-1));
         end
         if (adp) adp_bclk_i = 1'b0; else pcm_bclk_i = 1'b0;
         step(SETTLE);
         check("R10 falling edge ignored", ser_o, exp_bit(adp, rate, pw, aw, k-1));
         pcm_bclk_i = 1'b1; adp_bclk_i = 1'b1;
         step(SETTLE);
         if (k % wrap_len(adp, rate) == 0)
            check(wreq, ser_o, exp_bit(adp, rate, pw, aw, k));
         else
            check("R5", ser_o, exp_bit(adp, rate, pw, aw, k));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      step(3);
      check("R1 oe in reset", oe_o, 1'b0);
      check("R1 ser in reset", ser_o, 1'b0);
      rst_n = 1'b1;
      step(SETTLE);
      check("R1 oe after reset", oe_o, 1'b0);
      check("R1 ser after reset", ser_o, 1'b0);
      frame_i = 1'b1;
      step(SETTLE);
      // directed corners
      run_frame(1'b0, 2'b00, 8'hA5, 5'h00, 17, 1'b1);  // R6 double wrap
      run_frame(1'b1, 2'b00, 8'h00, 5'b10110, 11, 1'b1); // R7
      run_frame(1'b1, 2'b01, 8'hFF, 5'b11001, 9, 1'b1);  // R8 bit 4 set
      run_frame(1'b1, 2'b11, 8'h00, 5'b10110, 8, 1'b0);  // R8
      run_frame(1'b1, 2'b10, 8'h3C, 5'b01101, 5, 1'b1);  // R8
      run_frame(1'b0, 2'b11, 8'h81, 5'h1F, 0, 1'b0);     // R4 no edges
      for (int t = 0; t < 30; t++) begin
         run_frame(1'($urandom), 2'($urandom), 8'($urandom), 5'($urandom),
                   int'($urandom_range(0, 13)), 1'($urandom));
      end
      frame_i = 1'b0;
      step(SETTLE);
      check("R2 final idle", oe_o, 1'b0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule